// File: doc/BRIEF.md
# Dual-Size Receive Buffer Allocator

The allocator places incoming packet bytes into host memory buffers drawn from two free pools, one of small buffers and one of large buffers. Both sizes are programmable (1 to 8191 bytes). Each pool has a local cache of free-buffer addresses. The caches are refilled by requesting bursts of descriptors from the host side. A descriptor is simply a 32-bit buffer start address, and the data is placed there directly.

The receive datapath offers one byte per cycle. While a buffer is open, the allocator shows the address where the next byte goes and how much room remains. When a buffer fills, or the packet ends, it emits a used-buffer record and opens the next buffer. The record holds the pool, start address, bytes written and a last-buffer flag. The storage mode decides which pool supplies each buffer: large only, small only, or one small buffer first and then large ones. A packet may span any number of buffers.

Top module: `rxbuf_alloc`

## Requirements
- R1: While reset is held, `usedValid`, `bufReady` and `fetchReq` are 0.
- R2: Every record that is not the last of its packet carries a byte count equal to its pool's configured size. A configured size of 0 acts as 1.
- R3: With `cfgMode` 0 or 3 (large only), every buffer comes from the large pool (`usedPool`=1).
- R4: With `cfgMode` 1 (small only), every buffer comes from the small pool (`usedPool`=0).
- R5: With `cfgMode` 2 (chained), each packet's first buffer is small and every following buffer of that packet is large.
- R6: In chained mode, if the small cache is empty when a packet's first buffer is needed, that buffer is taken from the large pool instead.
- R7: The byte with `wrLast`=1 closes the open buffer. It produces a record with `usedLast`=1 and the partial count, and the next packet opens a fresh buffer.
- R8: Buffers of a pool are used in descriptor arrival order. While `bufReady`=1, `curAddr` is the buffer start plus the bytes already written, and `curRoom` is the size minus those bytes.
- R9: `fetchLen` is 1, 8 or 16 for `cfgBurst` 0, 1, or 2/3 respectively.
- R10: A refill is requested only for a pool the mode uses. It is requested when that cache holds fewer entries than the burst and has room for a whole burst.
- R11: A raised `fetchReq` holds, with stable `fetchPool` and `fetchLen`, until `fetchAck`. The next `fetchLen` cycles with `descValid` deliver the addresses into that pool.
- R12: When a byte is waiting and the required pool's cache is empty, `starve`=1 and `bufReady`=0. Outside the R6 case, the other pool is not used instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgSmallSize | input | 13 | Small buffer size in bytes |
| cfgLargeSize | input | 13 | Large buffer size in bytes |
| cfgMode | input | 2 | 0/3 large only, 1 small only, 2 small then large |
| cfgBurst | input | 2 | Refill burst: 0 one, 1 eight, 2/3 sixteen |
| fetchReq | output | 1 | Descriptor burst request pending |
| fetchPool | output | 1 | Pool of the request (0 small, 1 large) |
| fetchLen | output | 5 | Number of descriptors requested |
| fetchAck | input | 1 | Request accepted |
| descValid | input | 1 | A descriptor address is delivered |
| descAddr | input | 32 | Delivered buffer start address |
| wrValid | input | 1 | A packet byte is offered |
| wrLast | input | 1 | The offered byte ends the packet |
| bufReady | output | 1 | A buffer is open; an offered byte is taken |
| curAddr | output | 32 | Address of the next byte |
| curRoom | output | 13 | Bytes left in the open buffer |
| starve | output | 1 | Byte waiting, required cache empty |
| usedValid | output | 1 | Used-buffer record valid |
| usedPool | output | 1 | Record's pool |
| usedAddr | output | 32 | Record's buffer start address |
| usedCount | output | 13 | Bytes written to the buffer |
| usedLast | output | 1 | Buffer ends its packet |

## Verification
A wrong fill counter shows up in `curAddr` and `curRoom` on the very next offered byte. It also shows as a wrong `usedCount` one cycle after the buffer closes. A corrupted cache pointer or pool choice appears at the next buffer's close as an address or pool that breaks the arrival order. A broken refill or handshake shows within a few cycles as a wrong `fetchLen` or pool at acceptance. Otherwise it shows as a packet that stalls with `starve` raised while descriptors should be present.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam logic POOL_SMALL = 1'b0;
  localparam logic POOL_LARGE = 1'b1;

  typedef enum logic [1:0] {
    MODE_LARGE     = 2'd0,
    MODE_SMALL     = 2'd1,
    MODE_CHAIN     = 2'd2,
    MODE_LARGE_ALT = 2'd3
  } store_mode_e;

  typedef struct packed {
    logic load;      // open a buffer from loadPool
    logic loadPool;
    logic accept;    // one byte written to the open buffer
    logic close;     // open buffer finished
    logic last;      // the finishing byte ends the packet
  } ctl_strobe_t;
endpackage

// File: rtl/rxbuf_cache.sv
module rxbuf_cache #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [W-1:0]     pushData,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             empty
);
  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign head  = store[rdPtr];
  assign empty = (count == '0);
endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
  import rxbuf_pkg::*;
#(
  parameter int CACHE_DEPTH = 32,
  parameter int LEN_W       = 5,
  localparam int CNT_W = $clog2(CACHE_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgMode,
  input  logic [1:0]       cfgBurst,
  input  logic [CNT_W-1:0] smallCount,
  input  logic [CNT_W-1:0] largeCount,
  input  logic [1:0]       cacheEmpty,
  output logic [1:0]       cachePush,
  output logic [1:0]       cachePop,
  output logic             fetchReq,
  output logic             fetchPool,
  output logic [LEN_W-1:0] fetchLen,
  input  logic             fetchAck,
  input  logic             descValid,
  input  logic             wrValid,
  input  logic             wrLast,
  input  logic             atLimit,
  output ctl_strobe_t      strobe,
  output logic             bufReady,
  output logic             starve
);
  logic [LEN_W-1:0] burstLen, remain;
  logic [CNT_W-1:0] burstCnt, roomLimit;
  logic useSmall, useLarge, needSmall, needLarge;
  logic outstanding, fillPool;
  logic active, firstOfPkt, wantPool, poolEmpty;

  always_comb begin
    case (cfgBurst)
      2'd0:    burstLen = LEN_W'(1);
      2'd1:    burstLen = LEN_W'(8);
      default: burstLen = LEN_W'(16);
    endcase
  end

  assign burstCnt  = CNT_W'(burstLen);
  assign roomLimit = CNT_W'(CACHE_DEPTH) - burstCnt;
  assign useSmall  = (cfgMode == MODE_SMALL) || (cfgMode == MODE_CHAIN);
  assign useLarge  = (cfgMode != MODE_SMALL);
  assign needSmall = useSmall && (smallCount < burstCnt) && (smallCount <= roomLimit);
  assign needLarge = useLarge && (largeCount < burstCnt) && (largeCount <= roomLimit);

  // Refill: one request or delivery in flight at a time.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchReq    <= 1'b0;
      fetchPool   <= POOL_SMALL;
      fetchLen    <= '0;
      outstanding <= 1'b0;
      remain      <= '0;
      fillPool    <= POOL_SMALL;
    end else begin
      if (fetchReq && fetchAck) begin
        fetchReq    <= 1'b0;
        outstanding <= 1'b1;
        remain      <= fetchLen;
        fillPool    <= fetchPool;
      end else if (!fetchReq && !outstanding && (needSmall || needLarge)) begin
        fetchReq  <= 1'b1;
        fetchPool <= needSmall ? POOL_SMALL : POOL_LARGE;
        fetchLen  <= burstLen;
      end
      if (outstanding && descValid) begin
        remain <= remain - 1'b1;
        if (remain == LEN_W'(1)) outstanding <= 1'b0;
      end
    end
  end

  assign cachePush[POOL_SMALL] = outstanding && descValid && (fillPool == POOL_SMALL);
  assign cachePush[POOL_LARGE] = outstanding && descValid && (fillPool == POOL_LARGE);

  // Pool choice for the next buffer.
  always_comb begin
    case (cfgMode)
      MODE_SMALL: wantPool = POOL_SMALL;
      MODE_CHAIN: wantPool = (firstOfPkt && !cacheEmpty[POOL_SMALL]) ? POOL_SMALL : POOL_LARGE;
      default:    wantPool = POOL_LARGE;
    endcase
  end

  assign poolEmpty = cacheEmpty[wantPool];

  always_comb begin
    strobe          = '0;
    strobe.load     = !active && wrValid && !poolEmpty;
    strobe.loadPool = wantPool;
    strobe.accept   = active && wrValid;
    strobe.close    = active && wrValid && (wrLast || atLimit);
    strobe.last     = wrLast;
  end

  assign cachePop[POOL_SMALL] = strobe.load && (wantPool == POOL_SMALL);
  assign cachePop[POOL_LARGE] = strobe.load && (wantPool == POOL_LARGE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active     <= 1'b0;
      firstOfPkt <= 1'b1;
    end else begin
      if (strobe.load) active <= 1'b1;
      if (strobe.close) begin
        active     <= 1'b0;
        firstOfPkt <= strobe.last;
      end
    end
  end

  assign bufReady = active;
  assign starve   = !active && wrValid && poolEmpty;
endmodule

// File: rtl/rxbuf_datapath.sv
module rxbuf_datapath
  import rxbuf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strobe,
  input  logic [ADDR_W-1:0] smallHead,
  input  logic [ADDR_W-1:0] largeHead,
  input  logic [SIZE_W-1:0] cfgSmallSize,
  input  logic [SIZE_W-1:0] cfgLargeSize,
  output logic              atLimit,
  output logic [ADDR_W-1:0] curAddr,
  output logic [SIZE_W-1:0] curRoom,
  output logic              usedValid,
  output logic              usedPool,
  output logic [ADDR_W-1:0] usedAddr,
  output logic [SIZE_W-1:0] usedCount,
  output logic              usedLast
);
  logic [ADDR_W-1:0] baseAddr;
  logic [SIZE_W-1:0] fill, bufSize, smallEff, largeEff;
  logic              bufPool;

  assign smallEff = (cfgSmallSize == '0) ? SIZE_W'(1) : cfgSmallSize;
  assign largeEff = (cfgLargeSize == '0) ? SIZE_W'(1) : cfgLargeSize;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr  <= '0;
      fill      <= '0;
      bufSize   <= '0;
      bufPool   <= POOL_SMALL;
      usedValid <= 1'b0;
      usedPool  <= POOL_SMALL;
      usedAddr  <= '0;
      usedCount <= '0;
      usedLast  <= 1'b0;
    end else begin
      if (strobe.load) begin
        baseAddr <= (strobe.loadPool == POOL_LARGE) ? largeHead : smallHead;
        bufSize  <= (strobe.loadPool == POOL_LARGE) ? largeEff : smallEff;
        bufPool  <= strobe.loadPool;
        fill     <= '0;
      end else if (strobe.accept) begin
        fill <= fill + 1'b1;
      end
      usedValid <= strobe.close;
      if (strobe.close) begin
        usedPool  <= bufPool;
        usedAddr  <= baseAddr;
        usedCount <= fill + 1'b1;
        usedLast  <= strobe.last;
      end
    end
  end

  assign atLimit = ((fill + 1'b1) == bufSize);
  assign curAddr = baseAddr + ADDR_W'(fill);
  assign curRoom = bufSize - fill;
endmodule

// File: rtl/rxbuf_alloc.sv
module rxbuf_alloc
  import rxbuf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 13,
  parameter int CACHE_DEPTH = 32,
  parameter int LEN_W       = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SIZE_W-1:0] cfgSmallSize,
  input  logic [SIZE_W-1:0] cfgLargeSize,
  input  logic [1:0]        cfgMode,
  input  logic [1:0]        cfgBurst,
  output logic              fetchReq,
  output logic              fetchPool,
  output logic [LEN_W-1:0]  fetchLen,
  input  logic              fetchAck,
  input  logic              descValid,
  input  logic [ADDR_W-1:0] descAddr,
  input  logic              wrValid,
  input  logic              wrLast,
  output logic              bufReady,
  output logic [ADDR_W-1:0] curAddr,
  output logic [SIZE_W-1:0] curRoom,
  output logic              starve,
  output logic              usedValid,
  output logic              usedPool,
  output logic [ADDR_W-1:0] usedAddr,
  output logic [SIZE_W-1:0] usedCount,
  output logic              usedLast
);
  localparam int CNT_W = $clog2(CACHE_DEPTH + 1);

  logic [1:0]        cachePush, cachePop, cacheEmpty;
  logic [ADDR_W-1:0] cacheHead  [2];
  logic [CNT_W-1:0]  cacheCount [2];
  ctl_strobe_t       strobe;
  logic              atLimit;

  for (genvar p = 0; p < 2; p++) begin : g_pool
    rxbuf_cache #(.W(ADDR_W), .DEPTH(CACHE_DEPTH)) u_cache (
      .clk      (clk),
      .rstN     (rstN),
      .push     (cachePush[p]),
      .pushData (descAddr),
      .pop      (cachePop[p]),
      .head     (cacheHead[p]),
      .count    (cacheCount[p]),
      .empty    (cacheEmpty[p])
    );
  end

  rxbuf_ctrl #(.CACHE_DEPTH(CACHE_DEPTH), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgMode    (cfgMode),
    .cfgBurst   (cfgBurst),
    .smallCount (cacheCount[POOL_SMALL]),
    .largeCount (cacheCount[POOL_LARGE]),
    .cacheEmpty (cacheEmpty),
    .cachePush  (cachePush),
    .cachePop   (cachePop),
    .fetchReq   (fetchReq),
    .fetchPool  (fetchPool),
    .fetchLen   (fetchLen),
    .fetchAck   (fetchAck),
    .descValid  (descValid),
    .wrValid    (wrValid),
    .wrLast     (wrLast),
    .atLimit    (atLimit),
    .strobe     (strobe),
    .bufReady   (bufReady),
    .starve     (starve)
  );

  rxbuf_datapath #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .smallHead    (cacheHead[POOL_SMALL]),
    .largeHead    (cacheHead[POOL_LARGE]),
    .cfgSmallSize (cfgSmallSize),
    .cfgLargeSize (cfgLargeSize),
    .atLimit      (atLimit),
    .curAddr      (curAddr),
    .curRoom      (curRoom),
    .usedValid    (usedValid),
    .usedPool     (usedPool),
    .usedAddr     (usedAddr),
    .usedCount    (usedCount),
    .usedLast     (usedLast)
  );
endmodule

// File: rtl/rxbuf_alloc_chk.sv
module rxbuf_alloc_chk #(
  parameter int SIZE_W = 13,
  parameter int LEN_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [SIZE_W-1:0] cfgSmallSize,
  input logic [SIZE_W-1:0] cfgLargeSize,
  input logic              fetchReq,
  input logic              fetchAck,
  input logic              fetchPool,
  input logic [LEN_W-1:0]  fetchLen,
  input logic              bufReady,
  input logic [SIZE_W-1:0] curRoom,
  input logic              starve,
  input logic              usedValid,
  input logic              usedPool,
  input logic [SIZE_W-1:0] usedCount,
  input logic              usedLast
);
  logic [SIZE_W-1:0] smallEff, largeEff;
  assign smallEff = (cfgSmallSize == '0) ? SIZE_W'(1) : cfgSmallSize;
  assign largeEff = (cfgLargeSize == '0) ? SIZE_W'(1) : cfgLargeSize;

  // R11
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq && !fetchAck |=> fetchReq && $stable(fetchPool) && $stable(fetchLen));

  // R9
  burst_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> (fetchLen == LEN_W'(1)) || (fetchLen == LEN_W'(8)) || (fetchLen == LEN_W'(16)));

  // R2
  full_buffer_chk: assert property (@(posedge clk) disable iff (!rstN)
    usedValid && !usedLast |-> usedCount == (usedPool ? largeEff : smallEff));

  // R7
  close_drops_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    usedValid |-> !bufReady && (usedCount != '0));

  // R12
  starve_no_buffer_chk: assert property (@(posedge clk) disable iff (!rstN)
    starve |-> !bufReady);

  // R8
  room_left_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufReady |-> curRoom != '0);
endmodule

bind rxbuf_alloc rxbuf_alloc_chk #(.SIZE_W(SIZE_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/test_rxbuf_alloc.sv
module test_rxbuf_alloc;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] cfgSmallSize = 13'd6;
  logic [12:0] cfgLargeSize = 13'd20;
  logic [1:0]  cfgMode = 2'd0;
  logic [1:0]  cfgBurst = 2'd1;
  logic        fetchReq, fetchPool;
  logic [4:0]  fetchLen;
  logic        fetchAck = 1'b0;
  logic        descValid = 1'b0;
  logic [31:0] descAddr = '0;
  logic        wrValid = 1'b0;
  logic        wrLast = 1'b0;
  logic        bufReady, starve, usedValid, usedPool, usedLast;
  logic [31:0] curAddr, usedAddr;
  logic [12:0] curRoom, usedCount;

  rxbuf_alloc i_rxbuf_alloc (.*);

  always #10 clk = ~clk;

  typedef struct {
    bit          pool;
    logic [31:0] addr;
    int          cnt;
    bit          last;
    int          size;
  } exp_t;

  exp_t  expArr [1024];
  int    wrIdx = 0;       // written by main flow
  int    rdIdx = 0;       // written by monitor
  int    useS = 0, useL = 0;
  int    startLen = 0, startReq = 0, startSeen = 0;
  int    pktRemain = 0, bytesInBuf = 0;
  int    rspLeft = 0, rspS = 0, rspL = 0;
  bit    rspPool = 1'b0;
  bit    holdSmall = 1'b0;
  string curTag = "R3";
  int    tChecks = 0, tFails = 0, mChecks = 0, mFails = 0;

  function automatic logic [31:0] smallAddr(input int k);
    return 32'h1000_0000 + 32'(k) * 32'h100;
  endfunction
  function automatic logic [31:0] largeAddr(input int k);
    return 32'h4000_0000 + 32'(k) * 32'h2000;
  endfunction

  task automatic monCheck(input bit ok, input string tag, input string what,
                          input longint act, input longint expv);
    mChecks++;
    if (!ok) begin
      mFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic tbCheck(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
    tChecks++;
    if (!ok) begin
      tFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // Monitor, byte driver and descriptor responder, all at the falling edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (usedValid) begin
        if (rdIdx >= wrIdx) begin
          monCheck(1'b0, curTag, "unexpected record", usedAddr, 0);
        end else begin
          monCheck(usedPool == expArr[rdIdx].pool, curTag, "record pool",
                   usedPool, expArr[rdIdx].pool);
          monCheck(usedAddr == expArr[rdIdx].addr, "R8", "record address",
                   usedAddr, expArr[rdIdx].addr);
          monCheck(int'(usedCount) == expArr[rdIdx].cnt, "R2", "record count",
                   usedCount, expArr[rdIdx].cnt);
          monCheck(usedLast == expArr[rdIdx].last, "R7", "record last flag",
                   usedLast, expArr[rdIdx].last);
          rdIdx++;
        end
        bytesInBuf = 0;
      end
      if (startReq != startSeen) begin
        pktRemain = startLen;
        startSeen = startReq;
      end
      if (pktRemain > 0) begin
        wrValid = 1'b1;
        wrLast  = (pktRemain == 1);
        if (bufReady) begin
          if (rdIdx < wrIdx) begin
            monCheck(curAddr == expArr[rdIdx].addr + 32'(bytesInBuf), "R8", "curAddr",
                     curAddr, expArr[rdIdx].addr + 32'(bytesInBuf));
            monCheck(int'(curRoom) == expArr[rdIdx].size - bytesInBuf, "R8", "curRoom",
                     curRoom, expArr[rdIdx].size - bytesInBuf);
          end
          bytesInBuf++;
          pktRemain--;
        end
      end else begin
        wrValid = 1'b0;
        wrLast  = 1'b0;
      end
      descValid = 1'b0;
      descAddr  = '0;
      if (rspLeft > 0) begin
        descValid = 1'b1;
        if (rspPool) begin descAddr = largeAddr(rspL); rspL++; end
        else         begin descAddr = smallAddr(rspS); rspS++; end
        rspLeft--;
      end
      if (fetchAck) begin
        fetchAck = 1'b0;
      end else if (fetchReq && !(holdSmall && fetchPool == 1'b0)) begin
        monCheck(int'(fetchLen) == ((cfgBurst == 2'd0) ? 1 : (cfgBurst == 2'd1) ? 8 : 16),
                 "R9", "fetchLen", fetchLen,
                 (cfgBurst == 2'd0) ? 1 : (cfgBurst == 2'd1) ? 8 : 16);
        monCheck((cfgMode == 2'd1) ? (fetchPool == 1'b0) :
                 (cfgMode == 2'd2) ? 1'b1 : (fetchPool == 1'b1),
                 "R10", "fetch pool vs mode", fetchPool, cfgMode);
        fetchAck = 1'b1;
        rspLeft  = int'(fetchLen);
        rspPool  = fetchPool;
      end
    end
  end

  task automatic pushExpected(input int len, input int mode, input bit fallback);
    int  rem = len;
    bit  first = 1'b1;
    while (rem > 0) begin
      bit pool;
      int sz, n;
      if (mode == 1)      pool = 1'b0;
      else if (mode == 2) pool = (first && !fallback) ? 1'b0 : 1'b1;
      else                pool = 1'b1;
      sz = pool ? 20 : 6;
      n  = (rem < sz) ? rem : sz;
      expArr[wrIdx].pool = pool;
      expArr[wrIdx].addr = pool ? largeAddr(useL) : smallAddr(useS);
      expArr[wrIdx].cnt  = n;
      expArr[wrIdx].last = (rem == n);
      expArr[wrIdx].size = sz;
      wrIdx++;
      if (pool) useL++; else useS++;
      rem  -= n;
      first = 1'b0;
    end
  endtask

  task automatic waitDone();
    int guard = 0;
    do begin
      @(posedge clk); #5;
      guard++;
    end while ((startSeen != startReq || pktRemain != 0 || rdIdx != wrIdx) && guard < 5000);
    tbCheck(guard < 5000, curTag, "packet completion", pktRemain, 0);
  endtask

  task automatic startPacket(input int len, input int mode, input bit fallback);
    pushExpected(len, mode, fallback);
    startLen = len;
    startReq++;
  endtask

  task automatic runPacket(input int len, input int mode, input bit fallback);
    startPacket(len, mode, fallback);
    waitDone();
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #5;
    // R1: reset state
    tbCheck(usedValid == 1'b0, "R1", "usedValid in reset", usedValid, 0);
    tbCheck(bufReady == 1'b0, "R1", "bufReady in reset", bufReady, 0);
    tbCheck(fetchReq == 1'b0, "R1", "fetchReq in reset", fetchReq, 0);
    rstN = 1'b1;
    idle(60);

    // R3: large-only, burst of eight, packet lengths 1..45
    curTag = "R3";
    for (int len = 1; len <= 45; len++) runPacket(len, 0, 1'b0);
    idle(60);

    // R6: chained mode with the small cache empty and its refill held back
    curTag = "R6";
    holdSmall = 1'b1;
    cfgBurst  = 2'd2;
    cfgMode   = 2'd2;
    runPacket(30, 2, 1'b1);
    holdSmall = 1'b0;
    idle(100);

    // R5: chained, burst of sixteen, lengths 1..40
    curTag = "R5";
    for (int len = 1; len <= 40; len++) runPacket(len, 2, 1'b0);
    idle(60);

    // R12: small-only, refill withheld, packet larger than the cache can hold
    curTag = "R12";
    cfgMode   = 2'd1;
    holdSmall = 1'b1;
    begin
      int guard = 0;
      int frozen;
      startPacket(200, 1, 1'b0);
      do begin
        @(posedge clk); #5;
        guard++;
      end while (!starve && guard < 3000);
      tbCheck(starve == 1'b1, "R12", "starve raised", starve, 1);
      tbCheck(bufReady == 1'b0, "R12", "no buffer while starved", bufReady, 0);
      frozen = pktRemain;
      idle(20);
      tbCheck(pktRemain == frozen, "R12", "no bytes taken while starved", pktRemain, frozen);
      tbCheck(starve == 1'b1, "R12", "starve persists", starve, 1);
      holdSmall = 1'b0;
      waitDone();
    end
    idle(40);

    // R4: small-only, lengths 1..15
    curTag = "R4";
    for (int len = 1; len <= 15; len++) runPacket(len, 1, 1'b0);
    idle(60);

    // R9/R3: large-only with single-descriptor refill, lengths 1..25
    curTag = "R3";
    cfgBurst = 2'd0;
    cfgMode  = 2'd3;
    for (int len = 1; len <= 25; len++) runPacket(len, 0, 1'b0);
    idle(40);

    tbCheck(rdIdx == wrIdx, "R7", "all records seen", rdIdx, wrIdx);
    $display("%0d/%0d checks passed", (tChecks + mChecks) - (tFails + mFails), tChecks + mChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", (tChecks + mChecks) - (tFails + mFails),
             tChecks + mChecks + 1);
    $finish;
  end
endmodule